// File: doc/BRIEF.md
# Circular-Buffer Address Generator

This block forms memory addresses for load and store traffic from a file of 32-bit pointer registers. On each access request it picks a pointer, forms a signed step from either a second register or an immediate, and produces one address. In pre-modify mode the address is the pointer plus the step, and the pointer is not changed. In post-modify mode the address is the unchanged pointer, and the stepped value is written back. The write-back is done in the same cycle, so the very next access already sees the new pointer.

The lowest pointer slots can each be tied to a circular buffer. Each such slot has a length register and a base register. A buffer may start at any byte address. When the length is nonzero, any stepped value that leaves the buffer is folded back inside it. This applies in both directions and to both modes. A side load port writes pointers, lengths and bases. Memory access and instruction decode belong to the surrounding pipeline.

The design is a single registered stage. It has no internal states or transitions: every accepted request yields an address exactly one cycle later.

Top module: `agu_circ`

## Requirements
- R1: After reset, `addr_valid` and `addr_out` are 0. Every pointer, length and base register holds 0.
- R2: `addr_valid` is 1 in the cycle after a cycle with `op_valid` high, and 0 in the cycle after a cycle with `op_valid` low. `addr_out` carries the address of that request.
- R3: Pre-modify (`op_post`=0) returns pointer plus step as the address and leaves the pointer register unchanged.
- R4: Post-modify (`op_post`=1) returns the current pointer as the address and writes pointer plus step back. A request in the next cycle uses the written value.
- R5: The step source follows `mod_sel`:
  - 0 selects register `mod_idx`.
  - 1 selects `imm_val[7:0]`, sign-extended.
  - 2 and 3 select all 32 bits of `imm_val`.
  
  Every step is treated as a two's-complement signed value.
- R6: Pointers 4 to 31, and pointers 0 to 3 whose length is 0, step linearly modulo 2^32.
- R7: For pointers 0 to 3 with a nonzero length L and base B, take a pointer inside [B, B+L-1] and a step whose magnitude is below L. The stepped value, for both the pre-modify address and the post-modify write-back, lands inside the buffer: offset (pointer−B+step) is reduced modulo L. B needs no alignment, and the buffer may cross 2^32.
- R8: The load port (`ld_en`) writes `ld_data` according to `ld_kind`:
  - 0 writes pointer `ld_idx`.
  - 1 writes the length of slot `ld_idx`.
  - 2 writes the base of slot `ld_idx`.
  - 3 writes nothing.
  
  Length and base loads with `ld_idx` of 4 or more are ignored. Ignored loads leave all later addresses unaffected.
- R9: When a load and an access fall in the same cycle, the access uses the register values from before the load. If the load and a post-modify write-back target the same pointer, the loaded value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Access request this cycle |
| op_post | input | 1 | 1 = post-modify, 0 = pre-modify |
| mod_sel | input | 2 | Step source select (see R5) |
| ptr_idx | input | 5 | Pointer register index |
| mod_idx | input | 5 | Register index used as step when `mod_sel`=0 |
| imm_val | input | 32 | Immediate step |
| ld_en | input | 1 | Register load strobe |
| ld_kind | input | 2 | 0 pointer, 1 length, 2 base, 3 none |
| ld_idx | input | 5 | Register index to load |
| ld_data | input | 32 | Value to load |
| addr_valid | output | 1 | Address output valid |
| addr_out | output | 32 | Generated address |

## Verification
A register load and an access can land in the same cycle, and they can target the same pointer or the same buffer's length. The bench drives both strobes on one clock edge in three cases:
- a post-modify whose pointer is being loaded;
- a pre-modify whose pointer is being loaded;
- a post-modify whose length register is being loaded.

In each case the bench checks that the returned address reflects the old contents. Follow-up zero-step or small-step pre-modify reads then show which value the pointer kept, and that the new length takes effect from the next access on.

// File: rtl/agu_pkg.sv
package agu_pkg;

    typedef enum logic [1:0] {
        MOD_REG   = 2'd0,
        MOD_IMM8  = 2'd1,
        MOD_IMM32 = 2'd2,
        MOD_IMMX  = 2'd3
    } mod_src_e;

    typedef enum logic [1:0] {
        LD_PTR  = 2'd0,
        LD_LEN  = 2'd1,
        LD_BASE = 2'd2,
        LD_NONE = 2'd3
    } ld_kind_e;

endpackage

// File: rtl/agu_modsel.sv
module agu_modsel
    import agu_pkg::*;
#(
    parameter int DW = 32,
    parameter int IW = 8
) (
    input  logic [1:0]    sel,
    input  logic [DW-1:0] reg_val,
    input  logic [DW-1:0] imm,
    output logic [DW-1:0] step
);

    localparam int EXT = DW - IW;

    always_comb begin
        unique case (mod_src_e'(sel))
            MOD_REG:   step = reg_val;
            MOD_IMM8:  step = {{EXT{imm[IW-1]}}, imm[IW-1:0]};
            MOD_IMM32: step = imm;
            MOD_IMMX:  step = imm;
            default:   step = imm;
        endcase
    end

endmodule

// File: rtl/agu_wrap.sv
module agu_wrap #(
    parameter int DW    = 32,
    parameter int NCIRC = 4
) (
    input  logic [DW-1:0] ptr,
    input  logic [DW-1:0] step,
    input  logic [DW-1:0] base,
    input  logic [DW-1:0] len,
    input  logic          circ_en,
    output logic [DW-1:0] result
);

    logic [DW-1:0] lin_sum;
    assign lin_sum = ptr + step;

    generate
        if (NCIRC > 0) begin : g_circ
            logic [DW-1:0]     rel;
            logic signed [DW:0] off_s;
            logic signed [DW:0] step_s;
            logic signed [DW:0] len_s;
            logic signed [DW:0] raw_s;
            logic signed [DW:0] fold_s;

            always_comb begin
                rel    = ptr - base;
                off_s  = $signed({1'b0, rel});
                step_s = $signed({step[DW-1], step});
                len_s  = $signed({1'b0, len});
                raw_s  = off_s + step_s;
                if (raw_s >= len_s) begin
                    fold_s = raw_s - len_s;
                end else if (raw_s < 0) begin
                    fold_s = raw_s + len_s;
                end else begin
                    fold_s = raw_s;
                end
                if (circ_en && (len != '0)) begin
                    result = base + fold_s[DW-1:0];
                end else begin
                    result = lin_sum;
                end
            end
        end else begin : g_lin
            assign result = lin_sum;
        end
    endgenerate

endmodule

// File: rtl/agu_regfile.sv
module agu_regfile
    import agu_pkg::*;
#(
    parameter int NREG  = 32,
    parameter int NCIRC = 4,
    parameter int DW    = 32,
    parameter int AW    = $clog2(NREG),
    parameter int CW    = (NCIRC > 1) ? $clog2(NCIRC) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_a_idx,
    input  logic [AW-1:0] rd_b_idx,
    output logic [DW-1:0] rd_a,
    output logic [DW-1:0] rd_b,
    output logic [DW-1:0] len_a,
    output logic [DW-1:0] base_a,
    output logic          circ_a,
    input  logic          wb_en,
    input  logic [AW-1:0] wb_idx,
    input  logic [DW-1:0] wb_data,
    input  logic          ld_en,
    input  logic [1:0]    ld_kind,
    input  logic [AW-1:0] ld_idx,
    input  logic [DW-1:0] ld_data
);

    logic [DW-1:0] ptr_q  [NREG];
    logic [DW-1:0] len_q  [NCIRC];
    logic [DW-1:0] base_q [NCIRC];

    logic ld_ptr, ld_len, ld_base, ld_slot_ok;
    logic [CW-1:0] ld_slot, rd_slot;

    assign ld_ptr     = ld_en && (ld_kind_e'(ld_kind) == LD_PTR);
    assign ld_len     = ld_en && (ld_kind_e'(ld_kind) == LD_LEN);
    assign ld_base    = ld_en && (ld_kind_e'(ld_kind) == LD_BASE);
    assign ld_slot_ok = (ld_idx < AW'(NCIRC));
    assign ld_slot    = ld_idx[CW-1:0];
    assign rd_slot    = rd_a_idx[CW-1:0];

    // pointer array: load overrides write-back when both hit one slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) ptr_q[i] <= '0;
        end else begin
            if (wb_en)  ptr_q[wb_idx] <= wb_data;
            if (ld_ptr) ptr_q[ld_idx] <= ld_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NCIRC; i++) begin
                len_q[i]  <= '0;
                base_q[i] <= '0;
            end
        end else begin
            if (ld_len && ld_slot_ok)  len_q[ld_slot]  <= ld_data;
            if (ld_base && ld_slot_ok) base_q[ld_slot] <= ld_data;
        end
    end

    assign rd_a   = ptr_q[rd_a_idx];
    assign rd_b   = ptr_q[rd_b_idx];
    assign circ_a = (rd_a_idx < AW'(NCIRC));
    assign len_a  = circ_a ? len_q[rd_slot]  : '0;
    assign base_a = circ_a ? base_q[rd_slot] : '0;

endmodule

// File: rtl/agu_circ.sv
module agu_circ
    import agu_pkg::*;
#(
    parameter int NREG  = 32,
    parameter int NCIRC = 4,
    parameter int DW    = 32,
    parameter int IW    = 8,
    parameter int AW    = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic          op_post,
    input  logic [1:0]    mod_sel,
    input  logic [AW-1:0] ptr_idx,
    input  logic [AW-1:0] mod_idx,
    input  logic [DW-1:0] imm_val,
    input  logic          ld_en,
    input  logic [1:0]    ld_kind,
    input  logic [AW-1:0] ld_idx,
    input  logic [DW-1:0] ld_data,
    output logic          addr_valid,
    output logic [DW-1:0] addr_out
);

    logic [DW-1:0] ptr_val;
    logic [DW-1:0] modreg_val;
    logic [DW-1:0] mod_val;
    logic [DW-1:0] len_val;
    logic [DW-1:0] base_val;
    logic          circ_sel;
    logic [DW-1:0] sum_val;
    logic [DW-1:0] addr_d;
    logic          wb_en;

    agu_regfile #(
        .NREG (NREG),
        .NCIRC(NCIRC),
        .DW   (DW),
        .AW   (AW)
    ) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_a_idx(ptr_idx),
        .rd_b_idx(mod_idx),
        .rd_a    (ptr_val),
        .rd_b    (modreg_val),
        .len_a   (len_val),
        .base_a  (base_val),
        .circ_a  (circ_sel),
        .wb_en   (wb_en),
        .wb_idx  (ptr_idx),
        .wb_data (sum_val),
        .ld_en   (ld_en),
        .ld_kind (ld_kind),
        .ld_idx  (ld_idx),
        .ld_data (ld_data)
    );

    agu_modsel #(
        .DW(DW),
        .IW(IW)
    ) u_mod (
        .sel    (mod_sel),
        .reg_val(modreg_val),
        .imm    (imm_val),
        .step   (mod_val)
    );

    agu_wrap #(
        .DW   (DW),
        .NCIRC(NCIRC)
    ) u_wrap (
        .ptr    (ptr_val),
        .step   (mod_val),
        .base   (base_val),
        .len    (len_val),
        .circ_en(circ_sel),
        .result (sum_val)
    );

    assign wb_en  = op_valid && op_post;
    assign addr_d = op_post ? ptr_val : sum_val;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_valid <= 1'b0;
            addr_out   <= '0;
        end else begin
            addr_valid <= op_valid;
            if (op_valid) addr_out <= addr_d;
        end
    end

endmodule

// File: rtl/agu_circ_chk.sv
module agu_circ_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          op_valid,
    input logic          op_post,
    input logic          addr_valid,
    input logic [DW-1:0] addr_out,
    input logic [DW-1:0] ptr_val,
    input logic [DW-1:0] mod_val,
    input logic [DW-1:0] len_val,
    input logic [DW-1:0] base_val,
    input logic          circ_sel,
    input logic [DW-1:0] sum_val
);

    logic [DW-1:0] rel_old, rel_new, step_mag;
    logic          circ_ok;

    assign rel_old  = ptr_val - base_val;
    assign rel_new  = sum_val - base_val;
    assign step_mag = mod_val[DW-1] ? (~mod_val + 1'b1) : mod_val;
    assign circ_ok  = circ_sel && (len_val != '0) && (rel_old < len_val) && (step_mag < len_val);

    AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> addr_valid); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !addr_valid); // R2
    AST_POST_OLD_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_post) |=> (addr_out == $past(ptr_val))); // R4
    AST_PRE_LINEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !op_post && (len_val == '0)) |=> (addr_out == $past(ptr_val + mod_val))); // R3
    AST_CIRC_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && circ_ok) |-> (rel_new < len_val)); // R7

endmodule

bind agu_circ agu_circ_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_post   (op_post),
    .addr_valid(addr_valid),
    .addr_out  (addr_out),
    .ptr_val   (ptr_val),
    .mod_val   (mod_val),
    .len_val   (len_val),
    .base_val  (base_val),
    .circ_sel  (circ_sel),
    .sum_val   (sum_val)
);

// File: tb/agu_circ_bench.sv
module agu_circ_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic        op_post = 1'b0;
    logic [1:0]  mod_sel = 2'd0;
    logic [4:0]  ptr_idx = 5'd0;
    logic [4:0]  mod_idx = 5'd0;
    logic [31:0] imm_val = 32'd0;
    logic        ld_en = 1'b0;
    logic [1:0]  ld_kind = 2'd0;
    logic [4:0]  ld_idx = 5'd0;
    logic [31:0] ld_data = 32'd0;
    logic        addr_valid;
    logic [31:0] addr_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] mp [32];
    logic [31:0] ml [4];
    logic [31:0] mb [4];

    always #2 clk = ~clk;

    agu_circ u_agu_circ (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_post(op_post),
        .mod_sel(mod_sel), .ptr_idx(ptr_idx), .mod_idx(mod_idx), .imm_val(imm_val),
        .ld_en(ld_en), .ld_kind(ld_kind), .ld_idx(ld_idx), .ld_data(ld_data),
        .addr_valid(addr_valid), .addr_out(addr_out)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] step_of(input logic [1:0] sel, input int mi, input logic [31:0] imm);
        if (sel == 2'd0) return mp[mi];
        if (sel == 2'd1) return {{24{imm[7]}}, imm[7:0]};
        return imm;
    endfunction

    // offset reduced modulo L with 64-bit arithmetic
    function automatic logic [31:0] stepped(input int p, input logic [31:0] s);
        longint off, t, len;
        logic [31:0] rel;
        if (p < 4 && ml[p] != 32'd0) begin
            rel = mp[p] - mb[p];
            off = longint'(rel);
            len = longint'(ml[p]);
            t = off + longint'($signed(s));
            t = ((t % len) + len) % len;
            return mb[p] + t[31:0];
        end
        return mp[p] + s;
    endfunction

    task automatic model_load(input logic [1:0] k, input int i, input logic [31:0] d);
        if (k == 2'd0) mp[i] = d;
        else if (k == 2'd1 && i < 4) ml[i] = d;
        else if (k == 2'd2 && i < 4) mb[i] = d;
    endtask

    task automatic load(input logic [1:0] k, input int i, input logic [31:0] d);
        ld_en = 1'b1; ld_kind = k; ld_idx = 5'(i); ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
        model_load(k, i, d);
    endtask

    task automatic access(input bit post, input logic [1:0] sel, input int p, input int mi,
                          input logic [31:0] imm, input bit lon, input logic [1:0] lk,
                          input int li, input logic [31:0] ld, input string req);
        logic [31:0] s, nxt, exp;
        s   = step_of(sel, mi, imm);
        nxt = stepped(p, s);
        exp = post ? mp[p] : nxt;
        op_valid = 1'b1; op_post = post; mod_sel = sel;
        ptr_idx = 5'(p); mod_idx = 5'(mi); imm_val = imm;
        ld_en = lon; ld_kind = lk; ld_idx = 5'(li); ld_data = ld;
        if (post) mp[p] = nxt;
        if (lon) model_load(lk, li, ld);
        @(negedge clk);
        op_valid = 1'b0; ld_en = 1'b0;
        chk(addr_valid == 1'b1, "R2 valid", {31'd0, addr_valid}, 32'd1);
        chk(addr_out == exp, req, addr_out, exp);
    endtask

    task automatic pre(input int p, input logic [1:0] sel, input logic [31:0] imm, input string req);
        access(1'b0, sel, p, 0, imm, 1'b0, 2'd0, 0, 32'd0, req);
    endtask

    task automatic post(input int p, input logic [1:0] sel, input logic [31:0] imm, input string req);
        access(1'b1, sel, p, 0, imm, 1'b0, 2'd0, 0, 32'd0, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual expired expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) mp[i] = 32'd0;
        for (int i = 0; i < 4; i++) begin ml[i] = 32'd0; mb[i] = 32'd0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(addr_valid == 1'b0, "R1 valid", {31'd0, addr_valid}, 32'd0);
        chk(addr_out == 32'd0, "R1 addr", addr_out, 32'd0);
        pre(3, 2'd2, 32'd0, "R1 ptr3 zero");
        pre(20, 2'd2, 32'd0, "R1 ptr20 zero");
        load(2'd0, 1, 32'd100);
        pre(1, 2'd1, 32'd5, "R1 len zero linear");
        // R2 idle gives no valid
        @(negedge clk);
        chk(addr_valid == 1'b0, "R2 idle", {31'd0, addr_valid}, 32'd0);

        // R3 / R4 / R5 / R6 linear paths
        load(2'd0, 7, 32'hFFFF_FFFE);
        pre(7, 2'd2, 32'd5, "R6 wrap 2^32 pre");
        pre(7, 2'd2, 32'd0, "R3 no writeback");
        post(7, 2'd3, 32'd5, "R4 post old ptr");
        pre(7, 2'd2, 32'd0, "R4 writeback");
        load(2'd0, 9, 32'hFFFF_FFFD);
        load(2'd0, 12, 32'd1000);
        access(1'b0, 2'd0, 12, 9, 32'h55, 1'b0, 2'd0, 0, 32'd0, "R5 reg step");
        pre(12, 2'd1, 32'h0000_0180, "R5 imm8 sign");
        pre(12, 2'd1, 32'h1234_5607, "R5 imm8 low bits");
        post(12, 2'd2, 32'hFFFF_FF00, "R5 imm32 post");
        post(12, 2'd1, 32'd3, "R4 back-to-back");
        pre(12, 2'd2, 32'd0, "R4 back-to-back result");

        // R8 ignored loads
        load(2'd1, 6, 32'd4);
        load(2'd2, 6, 32'd0);
        load(2'd0, 6, 32'd10);
        pre(6, 2'd1, 32'd7, "R8 len idx6 ignored");
        load(2'd0, 8, 32'd77);
        load(2'd3, 8, 32'd55);
        pre(8, 2'd2, 32'd0, "R8 kind3 ignored");

        // R7 sweep over the circular slots
        for (int r = 0; r < 4; r++) begin
            logic [31:0] b;
            int len;
            b = 32'(1003 + 517 * r);
            len = 5 + r;
            load(2'd2, r, b);
            load(2'd1, r, 32'(len));
            for (int off = 0; off < len; off++) begin
                for (int m = -(len - 1); m < len; m++) begin
                    load(2'd0, r, b + 32'(off));
                    pre(r, 2'd1, 32'(m), "R7 pre fold");
                    post(r, 2'd1, 32'(m), "R7 post addr");
                    pre(r, 2'd2, 32'd0, "R7 post fold");
                end
            end
        end
        // R7 buffer crossing 2^32, register step
        load(2'd2, 3, 32'hFFFF_FFFE);
        load(2'd1, 3, 32'd4);
        load(2'd0, 3, 32'd0);
        pre(3, 2'd1, 32'd3, "R7 cross top");
        load(2'd0, 10, 32'hFFFF_FFFE);
        access(1'b1, 2'd0, 3, 10, 32'd0, 1'b0, 2'd0, 0, 32'd0, "R7 reg step post");
        pre(3, 2'd2, 32'd0, "R7 reg step result");

        // R9 concurrent load and access
        load(2'd0, 10, 32'd50);
        access(1'b1, 2'd1, 10, 0, 32'd4, 1'b1, 2'd0, 10, 32'd200, "R9 post with load");
        pre(10, 2'd2, 32'd0, "R9 load wins");
        load(2'd0, 11, 32'd60);
        access(1'b0, 2'd1, 11, 0, 32'd1, 1'b1, 2'd0, 11, 32'd300, "R9 pre old value");
        pre(11, 2'd2, 32'd0, "R9 pre load kept");
        load(2'd2, 1, 32'd0);
        load(2'd1, 1, 32'd0);
        load(2'd0, 1, 32'd3);
        access(1'b1, 2'd1, 1, 0, 32'd1, 1'b1, 2'd1, 1, 32'd5, "R9 len same cycle");
        pre(1, 2'd1, 32'd2, "R9 len next access");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule